// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers six interrupt requests (two external pins, two timer overflows, a serial request formed from receive or transmit, and a timer-2 group). It masks them with a global enable and one enable per source. It places each request in either a high or a low preemption level, chooses one winner, and hands the core a fixed vector address together with the level and the source number. When the core takes the interrupt it pulses `ack`. When the routine ends it pulses `reti`.

Each external pin can be configured as a level-sensed input (active low) or as a falling-edge input that latches into a flag. Timer overflow pulses also latch into flags. When the interrupt is vectored, the block clears the edge flag or timer flag of the chosen source. The serial and timer-2 requests are plain levels that software removes at their origin. Two in-service bits, one per level, stop a routine from being preempted by a request of equal or lower level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Source numbers 0..5 are external 0, timer 0, external 1, timer 1, serial, timer 2. The vector presented for source n is 0x0003 + 8*n, so the vectors are 0x0003, 0x000B, 0x0013, 0x001B, 0x0023 and 0x002B.
- R2: Among active requests of the same level, the lowest source number wins (external 0 first, timer 2 last).
- R3: Priority bit n (of `pri_reg[5:0]`) set to 1 puts source n in the high level. A high-level request wins over any low-level request, whatever the source numbers.
- R4: Enable bit n (`en_reg[5:0]`) gates source n. `en_reg[7]` = 0 blocks all requests (`irq_valid` = 0). Bit 6 of either register has no effect.
- R5: While the high in-service bit is set, no request is presented. While only the low in-service bit is set, only high-level requests are presented.
- R6: With `ext_edge_mode[i]` = 1, a pin sampled high on one clock and low on the next sets that pin's flag. The flag stays set after the pin returns high.
- R7: With `ext_edge_mode[i]` = 0, the request follows the inverted pin directly, and the pin's flag is held at 0.
- R8: `ack` while `irq_valid` is high sets the in-service bit of `irq_level`. It also clears the flag of the granted source if that source is an external pin in edge mode or a timer 0/1 overflow. `flag_q` bit order is {timer1, ext1, timer0, ext0}.
- R9: Serial and timer-2 requests are not cleared by `ack`. They stay presented after the routine returns.
- R10: `reti` clears the high in-service bit if it is set. Otherwise it clears the low in-service bit.
- R11: After reset, `irq_valid`, `flag_q` and `in_svc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_n | input | 2 | External interrupt pins, active low |
| ext_edge_mode | input | 2 | 1 = falling edge latched, 0 = low level |
| tmr_ovf | input | 2 | Timer 0/1 overflow pulses |
| ser_rx_req | input | 1 | Serial receive request |
| ser_tx_req | input | 1 | Serial transmit request |
| tmr2_req | input | 1 | Timer-2 group request |
| en_reg | input | 8 | Global enable (bit 7) and per-source enables |
| pri_reg | input | 8 | Per-source level select, 1 = high |
| ack | input | 1 | Core takes the presented interrupt |
| reti | input | 1 | Return from the current routine |
| irq_valid | output | 1 | An interrupt is presented |
| irq_level | output | 1 | Level of the presented interrupt, 1 = high |
| irq_src | output | 3 | Number of the presented source |
| irq_vector | output | 16 | Vector address of the presented source |
| flag_q | output | 4 | Latched flags {tmr1, ext1, tmr0, ext0} |
| in_svc | output | 2 | In-service bits {high, low} |

## Verification
The bench applies every combination of the six requests against every priority setting with all enables on. This separates the within-level ordering from the cross-level choice and checks the vector arithmetic for each winner. A second sweep applies every per-source enable mask to all six requests at once, and a third applies all requests with the global enable off. Directed sequences then cover the edge and level pin modes, the flag clearing on acknowledge, nesting and unwinding through `reti`, and the serial request that persists after its routine.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter int          VEC_STEP = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ext_n,
  input  logic [1:0]  ext_edge_mode,
  input  logic [1:0]  tmr_ovf,
  input  logic        ser_rx_req,
  input  logic        ser_tx_req,
  input  logic        tmr2_req,
  input  logic [7:0]  en_reg,
  input  logic [7:0]  pri_reg,
  input  logic        ack,
  input  logic        reti,
  output logic        irq_valid,
  output logic        irq_level,
  output logic [2:0]  irq_src,
  output logic [15:0] irq_vector,
  output logic [3:0]  flag_q,
  output logic [1:0]  in_svc
);
  localparam int NSRC = 6;

  logic [1:0] ext_prev, ext_flag, tmr_flag, ext_src;
  logic [NSRC-1:0] req, act, hi, lo;
  logic [2:0] hi_idx, lo_idx;
  logic hi_any, lo_any, use_hi, use_lo, take;

  assign ext_src = (ext_edge_mode & ext_flag) | (~ext_edge_mode & ~ext_n);
  assign req = {tmr2_req, ser_rx_req | ser_tx_req, tmr_flag[1], ext_src[1], tmr_flag[0], ext_src[0]};
  assign act = req & en_reg[NSRC-1:0] & {NSRC{en_reg[7]}};
  assign hi  = act & pri_reg[NSRC-1:0];
  assign lo  = act & ~pri_reg[NSRC-1:0];

  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int n = NSRC-1; n >= 0; n--) begin
      if (hi[n]) hi_idx = 3'(n);
      if (lo[n]) lo_idx = 3'(n);
    end
  end

  assign hi_any = |hi;
  assign lo_any = |lo;
  assign use_hi = hi_any & ~in_svc[1];
  assign use_lo = ~hi_any & lo_any & (in_svc == 2'b00);

  assign irq_valid  = use_hi | use_lo;
  assign irq_level  = use_hi;
  assign irq_src    = use_hi ? hi_idx : lo_idx;
  assign irq_vector = VEC_BASE + 16'(VEC_STEP) * {13'd0, irq_src};
  assign take       = ack & irq_valid;
  assign flag_q     = {tmr_flag[1], ext_flag[1], tmr_flag[0], ext_flag[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev <= 2'b11;
      ext_flag <= 2'b00;
      tmr_flag <= 2'b00;
    end else begin
      ext_prev <= ext_n;
      for (int i = 0; i < 2; i++) begin
        if (!ext_edge_mode[i])
          ext_flag[i] <= 1'b0;
        else if (ext_prev[i] && !ext_n[i])
          ext_flag[i] <= 1'b1;
        else if (take && irq_src == 3'(2*i))
          ext_flag[i] <= 1'b0;
        if (tmr_ovf[i])
          tmr_flag[i] <= 1'b1;
        else if (take && irq_src == 3'(2*i+1))
          tmr_flag[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_svc <= 2'b00;
    end else begin
      logic [1:0] nxt;
      nxt = in_svc;
      if (reti) begin
        if (nxt[1]) nxt[1] = 1'b0;
        else        nxt[0] = 1'b0;
      end
      if (take) nxt[irq_level] = 1'b1;
      in_svc <= nxt;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  ext_edge_mode,
  input logic [1:0]  tmr_ovf,
  input logic [7:0]  en_reg,
  input logic        ack,
  input logic        reti,
  input logic        irq_valid,
  input logic        irq_level,
  input logic [2:0]  irq_src,
  input logic [15:0] irq_vector,
  input logic [3:0]  flag_q,
  input logic [1:0]  in_svc
);
  a_r1_vector_map: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector == 16'h0003 + 16'd8 * {13'd0, irq_src}) && irq_src <= 3'd5);
  a_r4_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_reg[7] |-> !irq_valid);
  a_r5_high_busy: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc[1] |-> !irq_valid);
  a_r5_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc[0] && irq_valid) |-> irq_level);
  a_r7_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ext_edge_mode[0]) |-> !flag_q[0]);
  a_r8_tmr0_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_valid && irq_src == 3'd1 && !tmr_ovf[0]) |=> !flag_q[1]);
  a_r8_svc_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_valid && irq_level && !reti) |=> in_svc[1]);
  a_r10_unwind: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack && in_svc == 2'b11) |=> in_svc == 2'b01);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ext_edge_mode(ext_edge_mode), .tmr_ovf(tmr_ovf),
  .en_reg(en_reg), .ack(ack), .reti(reti), .irq_valid(irq_valid),
  .irq_level(irq_level), .irq_src(irq_src), .irq_vector(irq_vector),
  .flag_q(flag_q), .in_svc(in_svc)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] ext_n = 2'b11, ext_edge_mode = 2'b00, tmr_ovf = 2'b00;
  logic ser_rx_req = 0, ser_tx_req = 0, tmr2_req = 0;
  logic [7:0] en_reg = 8'h00, pri_reg = 8'h00;
  logic ack = 0, reti = 0;
  logic irq_valid, irq_level;
  logic [2:0] irq_src;
  logic [15:0] irq_vector;
  logic [3:0] flag_q;
  logic [1:0] in_svc;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_prio_ctrl dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ext_n = 2'b11; tmr_ovf = 0; ser_rx_req = 0; ser_tx_req = 0;
    tmr2_req = 0; ack = 0; reti = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse(output logic sig_unused);
    sig_unused = 0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1; step(); @(negedge clk); ack = 0;
  endtask

  task automatic do_reti();
    @(negedge clk); reti = 1; step(); @(negedge clk); reti = 0;
  endtask

  task automatic apply(input logic [5:0] m, input logic [7:0] en, input logic [7:0] pri);
    do_reset();
    en_reg = en; pri_reg = pri; ext_edge_mode = 2'b00;
    ext_n = {~m[2], ~m[0]};
    ser_rx_req = m[4]; tmr2_req = m[5];
    tmr_ovf = {m[3], m[1]};
    step();
    @(negedge clk); tmr_ovf = 0; #1;
  endtask

  task automatic expect_grant(string req, input logic [5:0] m, input logic [7:0] en, input logic [7:0] pri);
    logic [5:0] a, h, l;
    int w; logic v, lv;
    a = m & en[5:0] & {6{en[7]}};
    h = a & pri[5:0]; l = a & ~pri[5:0];
    w = 0; v = 0; lv = 0;
    if (h != 0) begin v = 1; lv = 1; for (int k = 5; k >= 0; k--) if (h[k]) w = k; end
    else if (l != 0) begin v = 1; for (int k = 5; k >= 0; k--) if (l[k]) w = k; end
    check({req, " valid"}, irq_valid, v);
    if (v) begin
      check({req, " level"}, irq_level, lv);
      check({req, " vector"}, irq_vector, 32'(3 + 8 * w));
    end
  endtask

  initial begin
    int c;
    c = 0;
    while (!done && c < 150000) begin @(posedge clk); c++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    do_reset(); #1;
    check("R11 valid", irq_valid, 0);
    check("R11 flags", flag_q, 0);
    check("R11 in_svc", in_svc, 0);

    // R1 R2 R3: all request patterns by all priority settings, bit 6 set (R4 reserved)
    for (int m = 0; m < 64; m++)
      for (int p = 0; p < 64; p++) begin
        apply(6'(m), 8'hFF, {2'b01, 6'(p)});
        expect_grant("R1/R2/R3", 6'(m), 8'hFF, {2'b01, 6'(p)});
      end

    // R4 individual enables
    for (int e = 0; e < 64; e++) begin
      apply(6'h3F, {2'b11, 6'(e)}, 8'h00);
      expect_grant("R4 enables", 6'h3F, {2'b11, 6'(e)}, 8'h00);
    end
    // R4 global enable off
    for (int m = 1; m < 64; m++) begin
      apply(6'(m), 8'h7F, 8'h15);
      check("R4 global off", irq_valid, 0);
    end

    // R5 R8 R10 nesting
    do_reset();
    en_reg = 8'hFF; pri_reg = 8'h02; ext_edge_mode = 2'b00;
    ext_n = 2'b10; #1;
    check("R7 level req vector", irq_vector, 16'h0003);
    check("R7 level req level", irq_level, 0);
    do_ack(); #1;
    check("R8 low in_svc", in_svc, 2'b01);
    check("R7 level no flag", flag_q[0], 0);
    check("R5 low blocked", irq_valid, 0);
    tmr_ovf = 2'b01; step(); @(negedge clk); tmr_ovf = 0; #1;
    check("R5 high preempts valid", irq_valid, 1);
    check("R5 high preempts vector", irq_vector, 16'h000B);
    do_ack(); #1;
    check("R8 high in_svc", in_svc, 2'b11);
    check("R8 timer flag cleared", flag_q[1], 0);
    check("R5 all blocked", irq_valid, 0);
    do_reti(); #1;
    check("R10 first reti", in_svc, 2'b01);
    check("R5 low still blocked", irq_valid, 0);
    do_reti(); #1;
    check("R10 second reti", in_svc, 2'b00);
    check("R7 level req returns", irq_vector, 16'h0003);
    ext_n = 2'b11; #1;
    check("R7 level release", irq_valid, 0);

    // R6 R8 edge mode on external 1
    do_reset();
    en_reg = 8'h84; pri_reg = 8'h00; ext_edge_mode = 2'b10;
    step(); @(negedge clk); ext_n = 2'b01; step();
    check("R6 edge flag set", flag_q[2], 1);
    @(negedge clk); ext_n = 2'b11; step();
    check("R6 flag held", flag_q[2], 1);
    check("R6 vector", irq_vector, 16'h0013);
    do_ack(); #1;
    check("R8 edge flag cleared", flag_q[2], 0);
    check("R8 edge no request", irq_valid, 0);

    // R9 serial persists
    do_reset();
    en_reg = 8'h90; pri_reg = 8'h00;
    ser_tx_req = 1; #1;
    check("R9 serial vector", irq_vector, 16'h0023);
    do_ack(); do_reti(); #1;
    check("R9 serial still valid", irq_valid, 1);
    check("R9 serial vector kept", irq_vector, 16'h0023);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule